// File: doc/BRIEF.md
# Inter-processor sync doorbell register

This block joins two processors, side A and side B, through one 32-bit register per side on a shared clock. Each side owns an 8-bit outgoing message byte. The other side can read that byte in its own register as soon as the write has landed. This gives the two processors a small mailbox that is independent of any bulk data channel.

Each side also has an interrupt enable for its own processor and a self-clearing trigger bit that rings the other side. A ring raises the remote processor's interrupt only if that processor has already set its enable. A ring that meets a cleared enable is lost. The interrupt is a sticky level that stays high until the local interrupt controller acknowledges it.

Both sides reach their register over a simple synchronous bus. The bus carries an address, write data, per-byte write enables and a read strobe. Read data is registered and returns one cycle after the strobe.

Top module: `ipc_sync_doorbell`

## Requirements
- R1: A write that hits the register address with byte enable 1 stores write-data bits 15:8 as the side's outgoing byte. That byte reads back in bits 15:8 of the same side.
- R2: Bits 7:0 of each side's read value equal the other side's outgoing byte. A read issued in the cycle after the other side's write already shows the new byte.
- R3: Bit 31 is the local interrupt enable. It is written through byte enable 3 and reads back in bit 31.
- R4: A field changes only when its own byte lane is enabled. Lane 0 (bits 7:0) and lane 2 have no writable fields, so writes to them change nothing.
- R5: Side A rings side B by writing 1 to bit 29 through lane 3. Side B rings side A by writing 1 to bit 30. If the target's enable is 1, the target's interrupt is high at the clock edge that takes the write.
- R6: A ring that arrives while the target's enable is 0 is dropped. Setting the enable afterwards does not raise the interrupt.
- R7: An interrupt stays high until its acknowledge input is 1 at a clock edge, and then it clears. If a gated ring and an acknowledge meet at the same edge, the interrupt stays high.
- R8: Bits 30:16 always read as 0, including both trigger bits. A side that writes the other side's trigger bit position causes no ring.
- R9: While reset is low, all read data, both outgoing bytes, both enables and both interrupts are 0.
- R10: A read strobe at the register address loads that cycle's register value into read data at the next edge. Without a strobe, or at any other address, read data is 0. Writes to other addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for both sides |
| rst_n | input | 1 | Synchronous active-low reset |
| a_addr | input | ADDR_W | Side A register address |
| a_be | input | 4 | Side A byte write enables; a nonzero value means a write |
| a_wdata | input | 32 | Side A write data |
| a_rd | input | 1 | Side A read strobe |
| a_rdata | output | 32 | Side A read data, registered |
| a_irq | output | 1 | Sticky sync interrupt to processor A |
| a_irq_ack | input | 1 | Acknowledge that clears a_irq |
| b_addr | input | ADDR_W | Side B register address |
| b_be | input | 4 | Side B byte write enables |
| b_wdata | input | 32 | Side B write data |
| b_rd | input | 1 | Side B read strobe |
| b_rdata | output | 32 | Side B read data, registered |
| b_irq | output | 1 | Sticky sync interrupt to processor B |
| b_irq_ack | input | 1 | Acknowledge that clears b_irq |

## Verification
The bound checker watches several rules on every cycle:
- each interrupt rises only after a ring from the other side that met a set enable;
- a ring against a cleared enable never sets an interrupt;
- an unacknowledged interrupt holds;
- the reserved read bits are zero;
- an idle read port returns zero;
- the cross-wired low byte matches the other side's outgoing byte;
- the outgoing byte is stable unless lane 1 is written.

Only the bench scenarios can show:
- the exact read-back values after mixed byte-lane writes;
- that enabling after a dropped ring leaves the interrupt low;
- that a ring wins over an acknowledge in the same cycle;
- that accesses at a wrong address have no effect;
- that a reset in mid-run clears everything.

// File: rtl/ipc_sync_pkg.sv
// Package: shared constants for the sync doorbell register.
// Assumes a 32-bit register split into four byte lanes. The bit positions
// below are fixed because each side decodes fields the other side drives.
package ipc_sync_pkg;
    localparam int SYNC_W   = 32;
    localparam int LANES    = SYNC_W / 8;
    localparam int MSG_W    = 8;
    localparam int RX_LSB   = 0;    // remote byte, read-only
    localparam int TX_LSB   = 8;    // local outgoing byte
    localparam int TX_LANE  = 1;
    localparam int CTL_LANE = 3;
    localparam int EN_BIT   = 31;

    // Trigger bit that a given side writes to ring the other side.
    function automatic int ring_bit(input int side);
        return (side == 0) ? 29 : 30;
    endfunction
endpackage

// File: rtl/sync_side_regs.sv
// Module: one side's sync register.
// Holds the outgoing byte and the local interrupt enable, decodes the
// byte-lane writes, produces a one-cycle ring pulse toward the other side
// and returns registered read data. Assumes a nonzero byte enable at the
// register address marks a write.
module sync_side_regs
    import ipc_sync_pkg::*;
#(
    parameter int          ADDR_W   = 4,
    parameter int unsigned REG_OFS  = 0,
    parameter int          RING_POS = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  be,
    input  logic [SYNC_W-1:0] wdata,
    input  logic              rd,
    input  logic [MSG_W-1:0]  remote_byte,
    output logic [SYNC_W-1:0] rdata,
    output logic [MSG_W-1:0]  tx_byte,
    output logic              irq_en,
    output logic              ring
);
    logic              sel;
    logic              wr_hit;
    logic [SYNC_W-1:0] view;
    logic              unused_wdata;

    assign sel          = (addr == ADDR_W'(REG_OFS));
    assign wr_hit       = sel && (|be);
    assign unused_wdata = ^wdata;

    // Ring pulse: lane 3 write with this side's trigger bit set.
    assign ring = wr_hit && be[CTL_LANE] && wdata[RING_POS];

    // Read view: remote byte low, own byte above, enable on top, rest zero.
    always_comb begin
        view                         = '0;
        view[RX_LSB +: MSG_W]        = remote_byte;
        view[TX_LSB +: MSG_W]        = tx_byte;
        view[EN_BIT]                 = irq_en;
    end

    // Writable fields, each updated only by its own byte lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_byte <= '0;
            irq_en  <= 1'b0;
        end else begin
            if (wr_hit && be[TX_LANE])
                tx_byte <= wdata[TX_LSB +: MSG_W];
            if (wr_hit && be[CTL_LANE])
                irq_en <= wdata[EN_BIT];
        end
    end

    // Registered read port: value on a strobe at the address, else zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd && sel)
            rdata <= view;
        else
            rdata <= '0;
    end
endmodule

// File: rtl/sync_irq_latch.sv
// Module: sticky interrupt for one processor.
// Set by a ring from the other side when the local enable is 1, cleared by
// acknowledge. If both happen at the same edge, the set wins.
module sync_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic ring_in,
    input  logic en,
    input  logic ack,
    output logic irq
);
    // Latch a gated ring; drop it when the enable is low.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (ring_in && en)
            irq <= 1'b1;
        else if (ack)
            irq <= 1'b0;
    end
endmodule

// File: rtl/ipc_sync_doorbell.sv
// Module: top of the two-sided sync doorbell.
// Instantiates one register and one interrupt latch per side and
// cross-wires the outgoing bytes and ring pulses. Assumes both sides share
// clk and the synchronous active-low reset.
module ipc_sync_doorbell
    import ipc_sync_pkg::*;
#(
    parameter int          ADDR_W  = 4,
    parameter int unsigned REG_OFS = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [3:0]        a_be,
    input  logic [31:0]       a_wdata,
    input  logic              a_rd,
    output logic [31:0]       a_rdata,
    output logic              a_irq,
    input  logic              a_irq_ack,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [3:0]        b_be,
    input  logic [31:0]       b_wdata,
    input  logic              b_rd,
    output logic [31:0]       b_rdata,
    output logic              b_irq,
    input  logic              b_irq_ack
);
    localparam int SIDES = 2;

    logic [SIDES-1:0][ADDR_W-1:0] addr_v;
    logic [SIDES-1:0][LANES-1:0]  be_v;
    logic [SIDES-1:0][SYNC_W-1:0] wdata_v;
    logic [SIDES-1:0][SYNC_W-1:0] rdata_v;
    logic [SIDES-1:0][MSG_W-1:0]  tx_byte;
    logic [SIDES-1:0]             rd_v;
    logic [SIDES-1:0]             ack_v;
    logic [SIDES-1:0]             irq_en;
    logic [SIDES-1:0]             ring;
    logic [SIDES-1:0]             irq_v;

    // Gather the two port sets into per-side vectors.
    assign addr_v  = {b_addr, a_addr};
    assign be_v    = {b_be, a_be};
    assign wdata_v = {b_wdata, a_wdata};
    assign rd_v    = {b_rd, a_rd};
    assign ack_v   = {b_irq_ack, a_irq_ack};

    assign a_rdata = rdata_v[0];
    assign b_rdata = rdata_v[1];
    assign a_irq   = irq_v[0];
    assign b_irq   = irq_v[1];

    for (genvar g = 0; g < SIDES; g++) begin : g_side
        sync_side_regs #(
            .ADDR_W   (ADDR_W),
            .REG_OFS  (REG_OFS),
            .RING_POS (ring_bit(g))
        ) u_regs (
            .clk         (clk),
            .rst_n       (rst_n),
            .addr        (addr_v[g]),
            .be          (be_v[g]),
            .wdata       (wdata_v[g]),
            .rd          (rd_v[g]),
            .remote_byte (tx_byte[SIDES-1-g]),
            .rdata       (rdata_v[g]),
            .tx_byte     (tx_byte[g]),
            .irq_en      (irq_en[g]),
            .ring        (ring[g])
        );

        sync_irq_latch u_irq (
            .clk     (clk),
            .rst_n   (rst_n),
            .ring_in (ring[SIDES-1-g]),
            .en      (irq_en[g]),
            .ack     (ack_v[g]),
            .irq     (irq_v[g])
        );
    end
endmodule

// File: rtl/ipc_sync_doorbell_chk.sv
// Module: assertion checker bound to ipc_sync_doorbell.
// Observes ports and the stored bytes and enables. Has no outputs.
module ipc_sync_doorbell_chk #(
    parameter int          ADDR_W  = 4,
    parameter int unsigned REG_OFS = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] a_addr,
    input logic [3:0]        a_be,
    input logic [31:0]       a_wdata,
    input logic              a_rd,
    input logic [31:0]       a_rdata,
    input logic              a_irq,
    input logic              a_irq_ack,
    input logic [ADDR_W-1:0] b_addr,
    input logic [3:0]        b_be,
    input logic [31:0]       b_wdata,
    input logic              b_rd,
    input logic [31:0]       b_rdata,
    input logic              b_irq,
    input logic              b_irq_ack,
    input logic [1:0][7:0]   tx_byte,
    input logic [1:0]        irq_en
);
    logic a_hit, b_hit, ring_from_a, ring_from_b;
    logic unused_chk;

    assign a_hit       = (a_addr == ADDR_W'(REG_OFS));
    assign b_hit       = (b_addr == ADDR_W'(REG_OFS));
    assign ring_from_a = a_hit && a_be[3] && a_wdata[29];
    assign ring_from_b = b_hit && b_be[3] && b_wdata[30];
    assign unused_chk  = ^{a_rdata[15:8], b_rdata[15:8], b_irq_ack};

    p_rise_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(a_irq) |-> $past(ring_from_b && irq_en[0]));
    p_rise_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(b_irq) |-> $past(ring_from_a && irq_en[1]));
    p_drop_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_from_b && !irq_en[0] && !a_irq) |=> !a_irq);
    p_hold_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (a_irq && !a_irq_ack) |=> a_irq);
    p_hold_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (b_irq && !b_irq_ack) |=> b_irq);
    p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (a_rdata[30:16] == '0) && (b_rdata[30:16] == '0));
    p_cross_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(a_rd && a_hit) |-> (a_rdata[7:0] == $past(tx_byte[1])));
    p_cross_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(b_rd && b_hit) |-> (b_rdata[7:0] == $past(tx_byte[0])));
    p_idle_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(a_rd) |-> (a_rdata == '0));
    p_idle_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(b_rd) |-> (b_rdata == '0));
    p_keep_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_hit && a_be[1]) |=> $stable(tx_byte[0]));
    p_keep_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(b_hit && b_be[1]) |=> $stable(tx_byte[1]));
endmodule

bind ipc_sync_doorbell ipc_sync_doorbell_chk #(
    .ADDR_W  (ADDR_W),
    .REG_OFS (REG_OFS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_addr    (a_addr),
    .a_be      (a_be),
    .a_wdata   (a_wdata),
    .a_rd      (a_rd),
    .a_rdata   (a_rdata),
    .a_irq     (a_irq),
    .a_irq_ack (a_irq_ack),
    .b_addr    (b_addr),
    .b_be      (b_be),
    .b_wdata   (b_wdata),
    .b_rd      (b_rd),
    .b_rdata   (b_rdata),
    .b_irq     (b_irq),
    .b_irq_ack (b_irq_ack),
    .tx_byte   (tx_byte),
    .irq_en    (irq_en)
);

// File: tb/ipc_sync_doorbell_test.sv
`timescale 1ns/1ps
// Bench: walks a table of writes and expected read-backs, then runs
// directed tests for reset, rings, acknowledge and address decode.
module ipc_sync_doorbell_test;
    localparam int ADDR_W = 4;
    localparam logic [ADDR_W-1:0] OFS = '0;
    localparam logic [ADDR_W-1:0] BAD = 4'd1;

    // Entry: side, be, wdata, expected A read, expected B read, irq A, irq B
    localparam int NV = 7;
    localparam logic [102:0] VEC [NV] = '{
        {1'b0, 4'b0010, 32'h0000_AB00, 32'h0000_AB00, 32'h0000_00AB, 2'b00},
        {1'b1, 4'b1111, 32'h8000_5A00, 32'h0000_AB5A, 32'h8000_5AAB, 2'b00},
        {1'b0, 4'b0001, 32'hFFFF_FFFF, 32'h0000_AB5A, 32'h8000_5AAB, 2'b00},
        {1'b0, 4'b1000, 32'hFFFF_C3FF, 32'h8000_AB5A, 32'h8000_5AAB, 2'b01},
        {1'b1, 4'b0100, 32'h00FF_0000, 32'h8000_AB5A, 32'h8000_5AAB, 2'b01},
        {1'b1, 4'b0010, 32'h0000_1200, 32'h8000_AB12, 32'h8000_12AB, 2'b01},
        {1'b0, 4'b1110, 32'h4000_3400, 32'h0000_3412, 32'h8000_1234, 2'b01}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ADDR_W-1:0] a_addr = '0, b_addr = '0;
    logic [3:0]  a_be = '0, b_be = '0;
    logic [31:0] a_wdata = '0, b_wdata = '0;
    logic        a_rd = 1'b0, b_rd = 1'b0;
    logic        a_irq_ack = 1'b0, b_irq_ack = 1'b0;
    logic [31:0] a_rdata, b_rdata;
    logic        a_irq, b_irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] rv;

    always #2 clk = ~clk;

    ipc_sync_doorbell #(.ADDR_W(ADDR_W), .REG_OFS(0)) uut (
        .clk(clk), .rst_n(rst_n),
        .a_addr(a_addr), .a_be(a_be), .a_wdata(a_wdata), .a_rd(a_rd),
        .a_rdata(a_rdata), .a_irq(a_irq), .a_irq_ack(a_irq_ack),
        .b_addr(b_addr), .b_be(b_be), .b_wdata(b_wdata), .b_rd(b_rd),
        .b_rdata(b_rdata), .b_irq(b_irq), .b_irq_ack(b_irq_ack)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int side, input logic [ADDR_W-1:0] ad,
                      input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        if (side == 0) begin a_addr = ad; a_be = be; a_wdata = d; end
        else           begin b_addr = ad; b_be = be; b_wdata = d; end
        @(negedge clk);
        a_be = '0; b_be = '0; a_addr = OFS; b_addr = OFS;
    endtask

    task automatic rd(input int side, input logic [ADDR_W-1:0] ad, output logic [31:0] v);
        @(negedge clk);
        if (side == 0) begin a_addr = ad; a_rd = 1'b1; end
        else           begin b_addr = ad; b_rd = 1'b1; end
        @(negedge clk);
        a_rd = 1'b0; b_rd = 1'b0; a_addr = OFS; b_addr = OFS;
        v = (side == 0) ? a_rdata : b_rdata;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset a_rdata", a_rdata, 32'h0);
        chk("R9 reset irqs", {30'h0, a_irq, b_irq}, 32'h0);
        rst_n = 1'b1;
        rd(0, OFS, rv); chk("R9 A after reset", rv, 32'h0);
        rd(1, OFS, rv); chk("R9 B after reset", rv, 32'h0);

        // Table walk: R1 R2 R3 R4 R5 R8
        for (int i = 0; i < NV; i++) begin
            wr(int'(VEC[i][102]), OFS, VEC[i][101:98], VEC[i][97:66]);
            chk($sformatf("R5 irq vec %0d", i), {30'h0, a_irq, b_irq}, {30'h0, VEC[i][1:0]});
            rd(0, OFS, rv); chk($sformatf("R1 R3 R4 A vec %0d", i), rv, VEC[i][65:34]);
            rd(1, OFS, rv); chk($sformatf("R2 R8 B vec %0d", i), rv, VEC[i][33:2]);
        end

        // R7: acknowledge clears B
        @(negedge clk); b_irq_ack = 1'b1;
        @(negedge clk); b_irq_ack = 1'b0;
        chk("R7 ack clears b_irq", {31'h0, b_irq}, 32'h0);

        // R6: ring to disabled A is dropped, later enable does not revive it
        wr(1, OFS, 4'b1000, 32'hC000_0000);
        chk("R6 dropped ring", {31'h0, a_irq}, 32'h0);
        wr(0, OFS, 4'b1000, 32'h8000_0000);
        repeat (2) @(negedge clk);
        chk("R6 enable after drop", {31'h0, a_irq}, 32'h0);

        // R5: ring with enable set
        wr(1, OFS, 4'b1000, 32'hC000_0000);
        chk("R5 ring B->A", {31'h0, a_irq}, 32'h1);
        rd(0, OFS, rv); chk("R8 trigger bits read 0", rv, 32'h8000_3412);

        // R7: hold, then ring and ack together, then ack alone
        repeat (3) @(negedge clk);
        chk("R7 irq holds", {31'h0, a_irq}, 32'h1);
        b_addr = OFS; b_be = 4'b1000; b_wdata = 32'hC000_0000; a_irq_ack = 1'b1;
        @(negedge clk);
        b_be = '0; a_irq_ack = 1'b0;
        chk("R7 set wins over ack", {31'h0, a_irq}, 32'h1);
        a_irq_ack = 1'b1;
        @(negedge clk); a_irq_ack = 1'b0;
        chk("R7 ack clears a_irq", {31'h0, a_irq}, 32'h0);

        // R10: wrong address is ignored, idle read data is zero
        wr(0, BAD, 4'b1111, 32'hE000_FF00);
        chk("R10 bad-address write no ring", {31'h0, b_irq}, 32'h0);
        rd(0, OFS, rv); chk("R10 bad-address write ignored", rv, 32'h8000_3412);
        rd(0, BAD, rv); chk("R10 bad-address read", rv, 32'h0);
        @(negedge clk);
        chk("R10 idle rdata", a_rdata, 32'h0);

        // R9: reset in mid-run
        wr(1, OFS, 4'b1000, 32'hC000_0000);
        chk("R5 ring before reset", {31'h0, a_irq}, 32'h1);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 irq cleared", {30'h0, a_irq, b_irq}, 32'h0);
        rst_n = 1'b1;
        rd(0, OFS, rv); chk("R9 A cleared", rv, 32'h0);
        rd(1, OFS, rv); chk("R9 B cleared", rv, 32'h0);

        summary();
        $finish;
    end
endmodule